// File: doc/BRIEF.md
# Hierarchical Interrupt Status Encoder

This block gathers interrupt requests from three priority tiers (critical, main and peripheral) and presents them to a processor as one read-only status word. For each tier the word carries a valid flag and the number of the lowest-numbered source that is both pending and enabled. A processor reads the word once and finds the source to service without scanning the raw request lines. Sense detection (edge or level) happens upstream, so every request input arrives here as a level.

Peripherals are not a separate branch of the tree. They reach the processor through the other tiers. A parameter splits the peripheral sources into a high set and a low set. Any enabled high-set request raises critical code 2, and any enabled low-set request raises main code 4. When software sees either code it reads the peripheral field. That field names the lowest enabled source in the high set if one exists, and otherwise the lowest in the low set.

Peripheral source 0 is not an external pin. It summarises a bank of DMA-task flags. Each flag is set by a task event and stays set until software writes a 1 to its position through the clear address. Each flag also has its own disable bit. Every mask register resets to all ones, so after reset no source is enabled. Writes use a single write port that selects one of five targets by address.

Top module: `irq_status_enc`

## Requirements
- R1: After reset the status word and the DMA pending vector read 0. Every mask bit resets to 1 (disabled), so no asserted request shows in the status word until its mask bit is written to 0.
- R2: Status bit 10 is 1 when any critical source n (0..3) has `crit_src[n]` high and critical mask bit n at 0. Bits 9:8 then hold the lowest such n. When bit 10 is 0, bits 9:8 read 0.
- R3: Status bit 21 is 1 when any main source n (0..16) is requested and main mask bit 16-n is 0. Bits 20:16 then hold the lowest such n.
- R4: Status bit 29 is 1 when any peripheral source n (0..31) is requested and peripheral mask bit 31-n is 0. Bits 28:24 hold a source number as R7 defines.
- R5: Critical source 2 is driven internally. It is high when an enabled peripheral source is in the high set (`HI_PERI_SET`, default bits 0 and 1). Input `crit_src[2]` is ignored.
- R6: Main source 4 is driven internally. It is high when an enabled peripheral source lies outside the high set. Input `main_src[4]` is ignored.
- R7: The peripheral field names the lowest enabled source in the high set when there is one. Otherwise it names the lowest enabled source in the low set.
- R8: Peripheral source 0 is requested when any DMA pending bit n is 1 and DMA mask bit n is 0. Input `peri_src[0]` is ignored.
- R9: DMA pending bit n becomes 1 on the clock edge after `dma_evt[n]` is high, and it holds until a write to address 4 with data bit n at 1. Such a write clears only the bits that are 1 in the data.
- R10: When `dma_evt[n]` is high in the same cycle as a clearing write to bit n, pending bit n stays 1.
- R11: Status bits outside 29:24, 21:16 and 10:8 always read 0.
- R12: A write with `wr_en` high updates one target per address: 0 critical mask (bit n for source n), 1 main mask, 2 peripheral mask, 3 DMA mask (bit n for task n), 4 DMA clear. Addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write target select |
| wr_data | input | 32 | Write data |
| crit_src | input | 4 | Critical request levels (bit 2 ignored) |
| main_src | input | 17 | Main request levels (bit 4 ignored) |
| peri_src | input | 32 | Peripheral request levels (bit 0 ignored) |
| dma_evt | input | N_DMA | DMA task completion events |
| status_word | output | 32 | Encoded status word |
| dma_pending | output | N_DMA | DMA pending flags |

## Verification
Two things can touch the DMA pending register in the same cycle: the set from a task event and the clear from a write. The bench drives a clearing write to address 4 together with `dma_evt` on bits that overlap and bits that do not. After the edge it compares `dma_pending` with an arithmetic model in which the set wins. Randomised cycles repeat this collision while the masks and request inputs also change. Each time, the full status word is rebuilt from the model, including the internal critical code 2 and main code 4.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

    localparam int CRIT_N = 4;
    localparam int MAIN_N = 17;
    localparam int PERI_N = 32;
    localparam int CRIT_W = $clog2(CRIT_N);
    localparam int MAIN_W = 5;
    localparam int PERI_W = $clog2(PERI_N);

    // positions of internally driven sources
    localparam int CRIT_PERI_CODE = 2;
    localparam int MAIN_PERI_CODE = 4;
    localparam int PERI_DMA_SRC   = 0;

    // status word layout
    localparam int ST_CRIT_VLD = 10;
    localparam int ST_CRIT_LSB = 8;
    localparam int ST_MAIN_VLD = 21;
    localparam int ST_MAIN_LSB = 16;
    localparam int ST_PERI_VLD = 29;
    localparam int ST_PERI_LSB = 24;
    localparam logic [31:0] ST_USED = 32'h3F3F_0700;

    typedef enum logic [2:0] {
        SEL_CRIT_MASK = 3'd0,
        SEL_MAIN_MASK = 3'd1,
        SEL_PERI_MASK = 3'd2,
        SEL_DMA_MASK  = 3'd3,
        SEL_DMA_CLR   = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic         vld,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = W'(i);
            end
        end
        vld = |req;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int         W       = 8,
    parameter logic [2:0] SEL     = 3'd0,
    parameter bit         REVERSE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] src,
    output logic [W-1:0] en,
    output logic [W-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en && (wr_addr == SEL)) begin
            mask_q <= wr_data;
        end
    end

    generate
        for (genvar n = 0; n < W; n++) begin : g_bit
            if (REVERSE) begin : g_rev
                assign en[n] = src[n] & ~mask_q[W-1-n];
            end else begin : g_fwd
                assign en[n] = src[n] & ~mask_q[n];
            end
        end
    endgenerate
endmodule

// File: rtl/irq_dma_unit.sv
module irq_dma_unit
    import irq_enc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [N-1:0] wr_data,
    input  logic [N-1:0] evt,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] mask_q,
    output logic         any_req
);
    logic [N-1:0] clr_vec;
    logic [N-1:0] pend_nxt;

    always_comb begin
        clr_vec  = (wr_en && (wr_addr == SEL_DMA_CLR)) ? wr_data : '0;
        pend_nxt = (pend_q & ~clr_vec) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en && (wr_addr == SEL_DMA_MASK)) begin
            mask_q <= wr_data;
        end
    end

    assign any_req = |(pend_q & ~mask_q);
endmodule

// File: rtl/irq_status_enc.sv
module irq_status_enc
    import irq_enc_pkg::*;
#(
    parameter int          N_DMA       = 32,
    parameter logic [31:0] HI_PERI_SET = 32'h0000_0003
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [3:0]       crit_src,
    input  logic [16:0]      main_src,
    input  logic [31:0]      peri_src,
    input  logic [N_DMA-1:0] dma_evt,
    output logic [31:0]      status_word,
    output logic [N_DMA-1:0] dma_pending
);
    logic                dma_req;
    logic [N_DMA-1:0]    dma_mask;
    logic [PERI_N-1:0]   peri_raw, peri_en, peri_mask, peri_hi, peri_lo, peri_pick;
    logic [CRIT_N-1:0]   crit_raw, crit_en, crit_mask;
    logic [MAIN_N-1:0]   main_raw, main_en, main_mask;
    logic                crit_vld, main_vld, peri_vld;
    logic [CRIT_W-1:0]   crit_idx;
    logic [MAIN_W-1:0]   main_idx;
    logic [PERI_W-1:0]   peri_idx;

    irq_dma_unit #(.N(N_DMA)) u_dma (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data[N_DMA-1:0]),
        .evt     (dma_evt),
        .pend_q  (dma_pending),
        .mask_q  (dma_mask),
        .any_req (dma_req)
    );

    always_comb begin
        peri_raw               = peri_src;
        peri_raw[PERI_DMA_SRC] = dma_req;
    end

    irq_mask_reg #(.W(PERI_N), .SEL(SEL_PERI_MASK), .REVERSE(1'b1)) u_peri_mask (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data[PERI_N-1:0]), .src (peri_raw), .en (peri_en),
        .mask_q (peri_mask)
    );

    always_comb begin
        peri_hi   = peri_en & HI_PERI_SET;
        peri_lo   = peri_en & ~HI_PERI_SET;
        peri_pick = (|peri_hi) ? peri_hi : peri_lo;
        crit_raw                 = crit_src;
        crit_raw[CRIT_PERI_CODE] = |peri_hi;
        main_raw                 = main_src;
        main_raw[MAIN_PERI_CODE] = |peri_lo;
    end

    irq_mask_reg #(.W(CRIT_N), .SEL(SEL_CRIT_MASK), .REVERSE(1'b0)) u_crit_mask (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data[CRIT_N-1:0]), .src (crit_raw), .en (crit_en),
        .mask_q (crit_mask)
    );

    irq_mask_reg #(.W(MAIN_N), .SEL(SEL_MAIN_MASK), .REVERSE(1'b1)) u_main_mask (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data[MAIN_N-1:0]), .src (main_raw), .en (main_en),
        .mask_q (main_mask)
    );

    irq_lowest_enc #(.N(CRIT_N), .W(CRIT_W)) u_crit_enc (
        .req (crit_en), .vld (crit_vld), .idx (crit_idx)
    );
    irq_lowest_enc #(.N(MAIN_N), .W(MAIN_W)) u_main_enc (
        .req (main_en), .vld (main_vld), .idx (main_idx)
    );
    irq_lowest_enc #(.N(PERI_N), .W(PERI_W)) u_peri_enc (
        .req (peri_pick), .vld (peri_vld), .idx (peri_idx)
    );

    always_comb begin
        status_word = '0;
        status_word[ST_CRIT_VLD] = crit_vld;
        status_word[ST_CRIT_LSB +: CRIT_W] = crit_idx;
        status_word[ST_MAIN_VLD] = main_vld;
        status_word[ST_MAIN_LSB +: MAIN_W] = main_idx;
        status_word[ST_PERI_VLD] = peri_vld;
        status_word[ST_PERI_LSB +: PERI_W] = peri_idx;
    end
endmodule

// File: rtl/irq_status_enc_chk.sv
module irq_status_enc_chk
    import irq_enc_pkg::*;
#(
    parameter int N_DMA = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic [N_DMA-1:0] dma_evt,
    input logic [N_DMA-1:0] dma_pending,
    input logic [N_DMA-1:0] dma_mask,
    input logic [31:0]      status_word
);
    logic [N_DMA-1:0] clr_now;
    assign clr_now = (wr_en && (wr_addr == SEL_DMA_CLR)) ? wr_data[N_DMA-1:0] : '0;

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & ~ST_USED) == 32'h0) else $error("unused status bit set"); // R11

    AST_CRIT_IDLE_NUM: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[ST_CRIT_VLD] |-> (status_word[9:8] == 2'd0)) else $error("critical number without flag"); // R2

    AST_DMA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(dma_pending) & ~$past(clr_now) & ~dma_pending) == '0)) else $error("pending bit lost"); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(dma_evt) & ~dma_pending) == '0)) else $error("event not captured"); // R10

    AST_DMA_SRC0: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[ST_PERI_VLD] && (status_word[28:24] == 5'd0)) |-> (|(dma_pending & ~dma_mask))) else $error("source 0 without DMA request"); // R8
endmodule

bind irq_status_enc irq_status_enc_chk #(.N_DMA(N_DMA)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .dma_evt     (dma_evt),
    .dma_pending (dma_pending),
    .dma_mask    (u_dma.mask_q),
    .status_word (status_word)
);

// File: tb/irq_status_enc_tb.sv
module irq_status_enc_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HI = 32'h0000_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  crit_src = '0;
    logic [16:0] main_src = '0;
    logic [31:0] peri_src = '0;
    logic [31:0] dma_evt = '0;
    logic [31:0] status_word;
    logic [31:0] dma_pending;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [3:0]  m_crit = '1;
    logic [16:0] m_main = '1;
    logic [31:0] m_peri = '1;
    logic [31:0] m_dmam = '1;
    logic [31:0] m_pend = '0;
    logic [31:0] lf = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_enc u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .crit_src (crit_src), .main_src (main_src),
        .peri_src (peri_src), .dma_evt (dma_evt), .status_word (status_word),
        .dma_pending (dma_pending)
    );

    function automatic int lowest(logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic [31:0] expect_status();
        logic [31:0] pen, hi, lo, r;
        logic [3:0]  cen;
        logic [16:0] men;
        logic s;
        for (int n = 0; n < 32; n++) begin
            s = (n == 0) ? |(m_pend & ~m_dmam) : peri_src[n];
            pen[n] = s & ~m_peri[31-n];
        end
        hi = pen & HI;
        lo = pen & ~HI;
        for (int n = 0; n < 4; n++) begin
            s = (n == 2) ? |hi : crit_src[n];
            cen[n] = s & ~m_crit[n];
        end
        for (int n = 0; n < 17; n++) begin
            s = (n == 4) ? |lo : main_src[n];
            men[n] = s & ~m_main[16-n];
        end
        r = '0;
        if (cen != 0) begin r[10] = 1'b1; r[9:8] = 2'(lowest({28'h0, cen})); end
        if (men != 0) begin r[21] = 1'b1; r[20:16] = 5'(lowest({15'h0, men})); end
        if (pen != 0) begin r[29] = 1'b1; r[28:24] = 5'(lowest((hi != 0) ? hi : lo)); end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_st(string req);
        chk(req, status_word, expect_status());
    endtask

    task automatic tick();
        logic [31:0] clr;
        @(posedge clk);
        clr = '0;
        if (wr_en) begin
            case (wr_addr)
                3'd0: m_crit = wr_data[3:0];
                3'd1: m_main = wr_data[16:0];
                3'd2: m_peri = wr_data;
                3'd3: m_dmam = wr_data;
                3'd4: clr = wr_data;
                default: ;
            endcase
        end
        m_pend = (m_pend & ~clr) | dma_evt;
        @(negedge clk);
        wr_en = 1'b0;
        dma_evt = '0;
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic step_lf();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", status_word, 32'h0);
        chk("R1", dma_pending, 32'h0);
        rst_n = 1'b1;
        #1;
        crit_src = '1; main_src = '1; peri_src = '1;
        #1;
        chk("R1", status_word, 32'h0);
        crit_src = '0; main_src = '0; peri_src = '0;

        // R2 critical sweep, R5 external bit 2 ignored
        wr(3'd0, 32'h0);
        for (int v = 0; v < 16; v++) begin
            crit_src = 4'(v); #1;
            chk_st("R2");
            if (v == 4) chk("R5", {31'h0, status_word[10]}, 32'h0);
        end
        crit_src = '0;

        // R3 main sweep, R6 external bit 4 ignored
        wr(3'd1, 32'h0);
        for (int n = 0; n < 17; n++) begin
            main_src = 17'(1 << n); #1;
            chk_st("R3");
            if (n == 4) chk("R6", {31'h0, status_word[21]}, 32'h0);
            main_src = main_src | 17'h1_0000; #1;
            chk_st("R3");
        end
        main_src = '0;

        // R4/R5/R6/R7 peripheral sweep
        wr(3'd2, 32'h0);
        for (int n = 1; n < 32; n++) begin
            peri_src = 32'h1 << n; #1;
            chk_st("R4");
            if (n < 2) chk("R5", {29'h0, status_word[10:8]}, 32'h6);
            else       chk("R6", {26'h0, status_word[21:16]}, 32'h24);
            peri_src = peri_src | 32'h2; #1;
            chk_st("R7");
            chk("R7", {27'h0, status_word[28:24]}, 32'h1);
        end
        peri_src = 32'h1; #1;
        chk_st("R8");
        chk("R8", {31'h0, status_word[29]}, 32'h0);

        // R12 mask field positions, one enabled source at a time
        crit_src = '1; main_src = '1; peri_src = '1;
        for (int k = 0; k < 32; k++) begin
            wr(3'd2, ~(32'h1 << (31 - k)));
            chk_st("R12");
        end
        for (int k = 0; k < 17; k++) begin
            wr(3'd1, ~(32'h1 << (16 - k)));
            chk_st("R3");
        end
        for (int k = 0; k < 4; k++) begin
            wr(3'd0, ~(32'h1 << k));
            chk_st("R2");
        end
        wr(3'd0, 32'hF); wr(3'd1, 32'h1_FFFF); wr(3'd2, 32'hFFFF_FFFF);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 32'h0);
            chk("R12", status_word, 32'h0);
        end
        crit_src = '0; main_src = '0; peri_src = '0;
        wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h0);

        // R8/R9 DMA sweep
        wr(3'd3, 32'h0);
        for (int t = 0; t < 32; t++) begin
            dma_evt = 32'h1 << t;
            tick();
            chk("R9", dma_pending, 32'h1 << t);
            chk_st("R8");
            wr(3'd4, 32'h1 << t);
            chk("R9", dma_pending, 32'h0);
        end
        dma_evt = 32'h5; tick();
        dma_evt = 32'h8; tick();
        chk("R9", dma_pending, 32'hD);
        wr(3'd4, 32'h4);
        chk("R9", dma_pending, 32'h9);
        wr(3'd3, 32'hFFFF_FFF6);
        chk_st("R8");
        wr(3'd3, 32'hFFFF_FFFF);
        chk_st("R8");
        chk("R8", {31'h0, status_word[29]}, 32'h0);

        // R10 set and clear in one cycle
        dma_evt = 32'h2;
        wr(3'd4, 32'h3);
        chk("R10", dma_pending, 32'hA);
        for (int t = 0; t < 32; t++) begin
            wr(3'd4, 32'hFFFF_FFFF);
            dma_evt = 32'h1 << t;
            wr(3'd4, 32'hFFFF_FFFF);
            chk("R10", dma_pending, 32'h1 << t);
        end

        // R11 randomised mix
        for (int i = 0; i < 400; i++) begin
            step_lf(); crit_src = lf[3:0]; main_src = lf[20:4];
            step_lf(); peri_src = lf;
            step_lf(); dma_evt = lf & {lf[7:0], lf[31:8]};
            step_lf(); wr_en = lf[0]; wr_addr = lf[3:1];
            step_lf(); wr_data = (lf[4] ? lf : ~lf);
            tick();
            chk_st("R11");
            chk("R11", status_word & ~32'h3F3F_0700, 32'h0);
            chk("R9", dma_pending, m_pend);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule